// File: doc/BRIEF.md
# Byte-wide I2C controller host register front end

This block is the processor-side register interface of an 8-bit I2C bus controller. A host reaches it through an 8-bit parallel bus with a chip select, separate read and write strobes, one register-select line and an interrupt-acknowledge line. All of these are sampled on the rising edge of the system clock. The block holds the control byte and a sticky status byte. It also holds a slave address register, an interrupt-vector register, a bus-clock configuration register and a data register. It drives an active-low interrupt request to the host.

A single select line is not enough to address six registers. The meaning of each access therefore depends on mode bits kept in the control byte: the serial-enable bit and two extension bits. When serial operation is off, the select-high address reads and writes the whole control byte. When serial operation is on, writes to that address still reach the control byte, but reads return a status view instead. An acknowledge read cycle, allowed only while interrupts are enabled, returns the vector register. The bit-level bus engine is not part of this block. Single-cycle stub inputs stand in for it: one marks the end of a byte, one sets status flags, and one delivers a received byte. The control, address, clock and data registers are brought out so that the engine can use them.

Control byte layout, bit 7 down to bit 0: pending-not (PND_N), serial enable (SEN), extension 1 (EX1), extension 2 (EX2), interrupt enable (IEN), start request, stop request, acknowledge control.

Top module: `i2c_hostreg_top`

## Requirements
- R1: After reset the control byte reads 0x80 (PND_N = 1, all other bits 0), all status flags are 0, the slave address, vector, clock and data registers are 0x00, and `irq_n` is 1.
- R2: With SEN = 0, an access with `reg_sel` = 1 reads and writes the full 8-bit control byte, whatever the extension bits hold.
- R3: With SEN = 0 and `reg_sel` = 0, extension bits EX1/EX2 = 0/0 select the slave address register, 0/1 the vector register and 1/0 the clock register, all read/write. The code 1/1 selects nothing: reads return 0x00 and writes change no register.
- R4: With SEN = 1 and `reg_sel` = 1, a write loads the control byte and a read returns the status view {PND_N, status[6:0]}.
- R5: With SEN = 1 and `reg_sel` = 0, EX1/EX2 = 0/0 selects the data register and 0/1 the vector register. EX1 = 1 selects nothing: reads return 0x00 and writes change no register.
- R6: When IEN = 1 and `iack_n` = 0 with `rd_n` = 0, the read returns the vector register, regardless of `cs_n`, `reg_sel` and the mode bits. When IEN = 0, `iack_n` has no effect.
- R7: `irq_n` is 0 exactly when IEN = 1 and PND_N = 0.
- R8: A pulse on `eng_byte_done` clears PND_N. Each bit set in `eng_stat_set` sets the matching status flag, and the flag stays set until it is cleared.
- R9: A control write with bit 7 = 1 clears every status flag. A status set in the same cycle loses to that clear.
- R10: A pulse on `eng_rx_valid` loads `eng_rx_byte` into the data register. A host write to the data register in the same cycle takes priority.
- R11: Read data appears on `host_rdata` one clock after the sampled read strobe. In any cycle with no read, it is 0x00 one clock later. An access with `cs_n` = 1 (and no acknowledge cycle) reads 0x00 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| reg_sel | input | 1 | Register select line |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq_n | output | 1 | Active-low interrupt request |
| eng_byte_done | input | 1 | Engine stub: byte transfer complete |
| eng_stat_set | input | 7 | Engine stub: status flags to set |
| eng_rx_valid | input | 1 | Engine stub: received byte valid |
| eng_rx_byte | input | 8 | Engine stub: received byte |
| ctl_o | output | 8 | Current control byte |
| own_addr_o | output | 8 | Slave address register |
| clk_cfg_o | output | 8 | Bus clock configuration register |
| tx_data_o | output | 8 | Data register |

## Verification
The assertions assume the engine stub inputs are single-cycle pulses that are 0 during reset. They also assume a host strobe is held for exactly one clock, and that write and read strobes are never low in the same cycle. The bench drives every host access as a one-cycle strobe on the falling edge and pulses the engine inputs for one cycle only. It changes mode bits only through separate control writes. The one deliberate overlap is a status set that coincides with a clearing control write, so that the priority rule is exercised.

// File: rtl/hr_pkg.sv
package hr_pkg;

    // Register selection resolved from mode bits, select line and acknowledge.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_OWN,
        SEL_VEC,
        SEL_CLK,
        SEL_DATA,
        SEL_ACKV
    } hr_sel_e;

    // Control byte bit positions (the bus engine decodes these).
    localparam int unsigned B_PND = 7;
    localparam int unsigned B_SEN = 6;
    localparam int unsigned B_EX1 = 5;
    localparam int unsigned B_EX2 = 4;
    localparam int unsigned B_IEN = 3;

    // Configuration register slots.
    localparam int unsigned NCFG    = 3;
    localparam int unsigned CFG_OWN = 0;
    localparam int unsigned CFG_VEC = 1;
    localparam int unsigned CFG_CLK = 2;

endpackage

// File: rtl/hr_decode.sv
module hr_decode
    import hr_pkg::*;
(
    input  logic    cs_n,
    input  logic    rd_n,
    input  logic    wr_n,
    input  logic    reg_sel,
    input  logic    iack_n,
    input  logic    sen,
    input  logic    ex1,
    input  logic    ex2,
    input  logic    ien,
    output hr_sel_e wr_sel,
    output hr_sel_e rd_sel,
    output logic    host_we,
    output logic    rd_act,
    output logic    ack_cyc
);

    hr_sel_e base_sel;
    logic    host_rd;

    always_comb begin
        host_rd = !cs_n && !rd_n;
        host_we = !cs_n && !wr_n;
        ack_cyc = ien && !iack_n && !rd_n;

        base_sel = SEL_NONE;
        if (reg_sel) begin
            base_sel = sen ? SEL_STAT : SEL_CTRL;
        end else begin
            case ({ex1, ex2})
                2'b00:   base_sel = sen ? SEL_DATA : SEL_OWN;
                2'b01:   base_sel = SEL_VEC;
                2'b10:   base_sel = sen ? SEL_NONE : SEL_CLK;
                default: base_sel = SEL_NONE;
            endcase
        end

        wr_sel = base_sel;
        rd_sel = ack_cyc ? SEL_ACKV : base_sel;
        rd_act = host_rd || ack_cyc;
    end

endmodule

// File: rtl/hr_ctrl.sv
module hr_ctrl
    import hr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_we,
    input  logic [DW-1:0] wdata,
    input  logic          byte_done,
    input  logic [DW-2:0] stat_set,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-2:0] status_q
);

    localparam int unsigned SW = DW - 1;
    localparam logic [DW-1:0] CTRL_RST = {1'b1, {(DW-1){1'b0}}};

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic [SW-1:0] stat;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stat = st_q.stat | stat_set;
        if (ctrl_we) begin
            st_d.ctrl = wdata;
            if (wdata[B_PND]) begin
                st_d.stat = '0;
            end
        end
        if (byte_done) begin
            st_d.ctrl[B_PND] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RST;
            st_q.stat <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q   = st_q.ctrl;
    assign status_q = st_q.stat;

    // R8: byte completion leaves the pending flag active (low)
    a_r8_done_clears_pnd: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !ctrl_q[B_PND]);

    // R8: set flags stick unless a clearing write coincides
    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl_we && wdata[B_PND])) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R9: writing the pending bit high empties the status
    a_r9_pnd_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && wdata[B_PND]) |=> (status_q == '0));

endmodule

// File: rtl/hr_regfile.sv
module hr_regfile
    import hr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  hr_sel_e       wr_sel,
    input  logic [DW-1:0] wdata,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] own_q,
    output logic [DW-1:0] vec_q,
    output logic [DW-1:0] clkr_q,
    output logic [DW-1:0] data_q
);

    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] cfg;
        logic [DW-1:0]           data;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [NCFG-1:0] cfg_we;
    logic            data_we;

    function automatic hr_sel_e cfg_code(input int unsigned idx);
        case (idx)
            CFG_OWN: return SEL_OWN;
            CFG_VEC: return SEL_VEC;
            default: return SEL_CLK;
        endcase
    endfunction

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg_we
        assign cfg_we[g] = host_we && (wr_sel == cfg_code(g));
    end

    assign data_we = host_we && (wr_sel == SEL_DATA);

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NCFG; i++) begin
            if (cfg_we[i]) begin
                rf_d.cfg[i] = wdata;
            end
        end
        if (data_we) begin
            rf_d.data = wdata;
        end else if (rx_valid) begin
            rf_d.data = rx_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign own_q  = rf_q.cfg[CFG_OWN];
    assign vec_q  = rf_q.cfg[CFG_VEC];
    assign clkr_q = rf_q.cfg[CFG_CLK];
    assign data_q = rf_q.data;

    // R3: an unselected write touches no configuration register
    a_r3_none_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && wr_sel == SEL_NONE) |=> $stable(rf_q.cfg));

    // R10: a received byte lands in the data register when the host is not writing it
    a_r10_rx_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !(host_we && wr_sel == SEL_DATA)) |=> (data_q == $past(rx_byte)));

endmodule

// File: rtl/hr_rdport.sv
module hr_rdport
    import hr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  hr_sel_e       rd_sel,
    input  logic [DW-1:0] ctrl,
    input  logic [DW-2:0] status,
    input  logic [DW-1:0] own,
    input  logic [DW-1:0] vec,
    input  logic [DW-1:0] clkr,
    input  logic [DW-1:0] data,
    output logic [DW-1:0] rdata_q
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rp_t;

    rp_t rp_d, rp_q;
    logic [DW-1:0] pick;

    always_comb begin
        case (rd_sel)
            SEL_CTRL:          pick = ctrl;
            SEL_STAT:          pick = {ctrl[B_PND], status};
            SEL_OWN:           pick = own;
            SEL_VEC, SEL_ACKV: pick = vec;
            SEL_CLK:           pick = clkr;
            SEL_DATA:          pick = data;
            default:           pick = '0;
        endcase
        rp_d.rdata = rd_act ? pick : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign rdata_q = rp_q.rdata;

endmodule

// File: rtl/i2c_hostreg_top.sv
module i2c_hostreg_top
    import hr_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          reg_sel,
    input  logic          iack_n,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq_n,
    input  logic          eng_byte_done,
    input  logic [DW-2:0] eng_stat_set,
    input  logic          eng_rx_valid,
    input  logic [DW-1:0] eng_rx_byte,
    output logic [DW-1:0] ctl_o,
    output logic [DW-1:0] own_addr_o,
    output logic [DW-1:0] clk_cfg_o,
    output logic [DW-1:0] tx_data_o
);

    hr_sel_e       wr_sel, rd_sel;
    logic          host_we, rd_act, ack_cyc, ctrl_we;
    logic [DW-1:0] ctrl_q, own_q, vec_q, clkr_q, data_q;
    logic [DW-2:0] status_q;

    hr_decode u_decode (
        .cs_n    (cs_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .reg_sel (reg_sel),
        .iack_n  (iack_n),
        .sen     (ctrl_q[B_SEN]),
        .ex1     (ctrl_q[B_EX1]),
        .ex2     (ctrl_q[B_EX2]),
        .ien     (ctrl_q[B_IEN]),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .host_we (host_we),
        .rd_act  (rd_act),
        .ack_cyc (ack_cyc)
    );

    assign ctrl_we = host_we && (wr_sel == SEL_CTRL || wr_sel == SEL_STAT);

    hr_ctrl #(.DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .wdata     (host_wdata),
        .byte_done (eng_byte_done),
        .stat_set  (eng_stat_set),
        .ctrl_q    (ctrl_q),
        .status_q  (status_q)
    );

    hr_regfile #(.DW(DW)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_we  (host_we),
        .wr_sel   (wr_sel),
        .wdata    (host_wdata),
        .rx_valid (eng_rx_valid),
        .rx_byte  (eng_rx_byte),
        .own_q    (own_q),
        .vec_q    (vec_q),
        .clkr_q   (clkr_q),
        .data_q   (data_q)
    );

    hr_rdport #(.DW(DW)) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_act  (rd_act),
        .rd_sel  (rd_sel),
        .ctrl    (ctrl_q),
        .status  (status_q),
        .own     (own_q),
        .vec     (vec_q),
        .clkr    (clkr_q),
        .data    (data_q),
        .rdata_q (host_rdata)
    );

    assign irq_n      = ~(ctrl_q[B_IEN] & ~ctrl_q[B_PND]);
    assign ctl_o      = ctrl_q;
    assign own_addr_o = own_q;
    assign clk_cfg_o  = clkr_q;
    assign tx_data_o  = data_q;

    // R6: an acknowledge cycle returns the vector register
    a_r6_ack_returns_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ack_cyc |=> (host_rdata == $past(vec_q)));

    // R7: the request only rises to active from a control write or a byte completion
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(ctrl_we) || $past(eng_byte_done)));

    // R11: no read means a zero bus one clock later
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> (host_rdata == '0));

endmodule

// File: tb/i2c_hostreg_top_tb.sv
module i2c_hostreg_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, reg_sel = 1'b0, iack_n = 1'b1;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       irq_n;
    logic       eng_byte_done = 1'b0;
    logic [6:0] eng_stat_set = '0;
    logic       eng_rx_valid = 1'b0;
    logic [7:0] eng_rx_byte = '0;
    logic [7:0] ctl_o, own_addr_o, clk_cfg_o, tx_data_o;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #2 clk = ~clk;

    i2c_hostreg_top u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n          (cs_n),
        .rd_n          (rd_n),
        .wr_n          (wr_n),
        .reg_sel       (reg_sel),
        .iack_n        (iack_n),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .irq_n         (irq_n),
        .eng_byte_done (eng_byte_done),
        .eng_stat_set  (eng_stat_set),
        .eng_rx_valid  (eng_rx_valid),
        .eng_rx_byte   (eng_rx_byte),
        .ctl_o         (ctl_o),
        .own_addr_o    (own_addr_o),
        .clk_cfg_o     (clk_cfg_o),
        .tx_data_o     (tx_data_o)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Monitor: the read data registered at the preceding edge is compared here.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            check(host_rdata, it.exp, it.tag);
        end
    end

    task automatic host_write(input logic sel, input logic [7:0] d, input logic cs = 1'b1);
        @(negedge clk);
        reg_sel = sel; host_wdata = d; cs_n = !cs; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1;
    endtask

    task automatic host_read(input logic sel, input logic [7:0] exp, input string tag,
                             input logic cs = 1'b1, input logic ack = 1'b0);
        @(negedge clk);
        reg_sel = sel; cs_n = !cs; iack_n = !ack; rd_n = 1'b0;
        @(posedge clk);
        sb.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        rd_n = 1'b1; cs_n = 1'b1; iack_n = 1'b1;
    endtask

    task automatic eng_pulse(input logic done, input logic [6:0] st,
                             input logic rxv, input logic [7:0] rxb);
        @(negedge clk);
        eng_byte_done = done; eng_stat_set = st; eng_rx_valid = rxv; eng_rx_byte = rxb;
        @(negedge clk);
        eng_byte_done = 1'b0; eng_stat_set = '0; eng_rx_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({7'b0, irq_n}, 8'h01, "R1 irq_n after reset");
        host_read(1'b1, 8'h80, "R1 control after reset");
        host_read(1'b0, 8'h00, "R1 slave address after reset");
        check(tx_data_o, 8'h00, "R1 data after reset");

        // R2 control byte, serial off
        host_write(1'b1, 8'h0F);
        check({7'b0, irq_n}, 8'h00, "R7 irq active with IEN=1 PND_N=0");
        host_read(1'b1, 8'h0F, "R2 control readback");
        host_write(1'b1, 8'hB0);
        host_read(1'b1, 8'hB0, "R2 control readback with EX1/EX2=11");
        check({7'b0, irq_n}, 8'h01, "R7 irq idle with IEN=0");

        // R3 configuration registers, serial off
        host_write(1'b0, 8'h77);
        host_read(1'b0, 8'h00, "R3 code 11 reads zero");
        host_write(1'b1, 8'h80);
        host_write(1'b0, 8'h55);
        host_write(1'b1, 8'h90);
        host_write(1'b0, 8'hA3);
        host_write(1'b1, 8'hA0);
        host_write(1'b0, 8'h1C);
        host_read(1'b0, 8'h1C, "R3 clock register");
        host_write(1'b1, 8'h90);
        host_read(1'b0, 8'hA3, "R3 vector register");
        host_write(1'b1, 8'h80);
        host_read(1'b0, 8'h55, "R3 slave address register");
        check(own_addr_o, 8'h55, "R3 code 11 write left slave address");

        // R4 / R5 serial on
        host_write(1'b1, 8'hC0);
        host_write(1'b0, 8'h3C);
        host_read(1'b0, 8'h3C, "R5 data register");
        host_read(1'b1, 8'h80, "R4 status view after setup");
        check(ctl_o, 8'hC0, "R4 control after write");
        host_write(1'b1, 8'hD0);
        host_read(1'b0, 8'hA3, "R5 vector with serial on");
        host_write(1'b1, 8'hE0);
        host_write(1'b0, 8'h11);
        host_read(1'b0, 8'h00, "R5 EX1=1 reads zero");
        host_write(1'b1, 8'hC0);
        host_read(1'b0, 8'h3C, "R5 EX1=1 write left data");
        check(clk_cfg_o, 8'h1C, "R5 EX1=1 write left clock");

        // R8 engine stub
        eng_pulse(1'b1, 7'h15, 1'b0, 8'h00);
        host_read(1'b1, 8'h15, "R8 status view after byte done");
        check({7'b0, irq_n}, 8'h01, "R7 irq idle with IEN=0 PND_N=0");
        host_write(1'b1, 8'h48);
        check({7'b0, irq_n}, 8'h00, "R7 irq active after IEN set");
        host_read(1'b1, 8'h15, "R8 flags held across control write");

        // R6 acknowledge cycle with chip select high
        host_read(1'b1, 8'hA3, "R6 ack cycle returns vector", 1'b0, 1'b1);

        // R9 clearing write
        host_write(1'b1, 8'hC8);
        check({7'b0, irq_n}, 8'h01, "R7 irq idle after PND_N write");
        host_read(1'b1, 8'h80, "R9 status cleared");
        eng_pulse(1'b0, 7'h22, 1'b0, 8'h00);
        @(negedge clk);
        reg_sel = 1'b1; host_wdata = 8'hC8; cs_n = 1'b0; wr_n = 1'b0; eng_stat_set = 7'h7F;
        @(negedge clk);
        wr_n = 1'b1; cs_n = 1'b1; eng_stat_set = '0;
        host_read(1'b1, 8'h80, "R9 clear beats simultaneous set");

        // R6 acknowledge ignored with IEN=0
        host_write(1'b1, 8'hC0);
        host_read(1'b1, 8'h80, "R6 iack ignored with IEN=0", 1'b1, 1'b1);

        // R10 received byte
        eng_pulse(1'b0, 7'h00, 1'b1, 8'hE7);
        host_read(1'b0, 8'hE7, "R10 received byte in data register");

        // R11 idle bus and deselected access
        @(negedge clk);
        check(host_rdata, 8'h00, "R11 no read gives zero");
        host_write(1'b0, 8'h12, 1'b0);
        host_read(1'b0, 8'h00, "R11 deselected read gives zero", 1'b0, 1'b0);
        host_read(1'b0, 8'hE7, "R11 deselected write ignored");

        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule